// File: doc/BRIEF.md
# Polled Keyboard and Display Port

This block places a keyboard input channel and a display output channel in the top page of a 16-bit address space. A processor bus access that targets the page at or above address xFE00 goes to four device registers, and the block holds the memory-enable output low so that main memory stays silent. A bus access below that boundary leaves the device untouched and raises memory enable. Software handles both channels by polling: it reads a status word, tests its most significant bit, and then moves a character through the data word that belongs to that channel.

The keyboard side takes bytes from a valid/ready stream. A byte that is accepted is latched into the data register and marks the keyboard status as ready. A bus read of the data register consumes the byte and opens the stream again. The display side is the mirror image. A bus write of the display data register presents the byte on an output stream and marks the display as busy. When the sink accepts the byte, the display is ready again. Each status word also holds an interrupt-enable bit. When that bit and the ready flag are both set, an interrupt request line goes high.

Two small state machines carry the channels. The keyboard machine has the states `KB_EMPTY` and `KB_FULL`. It moves from `KB_EMPTY` to `KB_FULL` on the transition "byte taken" and back on "byte read". The display machine has the states `DS_IDLE` and `DS_BUSY`. It moves from `DS_IDLE` to `DS_BUSY` on "byte written" and back on "byte accepted".

Top module: `kbd_disp_port`

## Requirements
- R1: After reset the keyboard status reads x0000 and the display status reads x8000. Both interrupt lines are low, the keyboard stream is ready and the display stream is not valid.
- R2: `mem_en` equals `bus_req` for addresses xFDFF and below, and is 0 for any address from xFE00 to xFFFF. `rd_data` is zero unless the access is a read into the device page.
- R3: When `kb_valid` and `kb_ready` are both high at an edge, from the next cycle the keyboard status (xFE00) has bit 15 = 1. The keyboard data word (xFE02) then holds the byte in bits 7:0 with bits 15:8 zero, and `kb_ready` is 0.
- R4: A bus read of xFE02 while a byte is held returns that byte. From the next cycle, bit 15 of the keyboard status is 0 and `kb_ready` is 1.
- R5: While a byte is held and not yet read, `kb_ready` stays 0 and the held byte does not change, whatever `kb_valid` and `kb_data` do.
- R6: A bus write of xFE06 while the display is ready makes, from the next cycle, display status bit 15 = 0, `dsp_valid` = 1 and `dsp_data` = write bits 7:0. A read of xFE06 returns that byte in bits 7:0.
- R7: `dsp_accept` while `dsp_valid` is high makes, from the next cycle, `dsp_valid` = 0 and display status bit 15 = 1.
- R8: A bus write of xFE06 while `dsp_valid` is high is ignored: `dsp_data` and the readable byte keep their values.
- R9: A bus write to a status word (xFE00 or xFE04) loads its bit 14, the interrupt enable, from write-data bit 14. Bit 15 of the written value is ignored. A write to xFE02 has no effect.
- R10: `kb_irq` = keyboard ready AND keyboard enable, and `dsp_irq` = display ready AND display enable, in every cycle.
- R11: Reads of any device-page address other than xFE00, xFE02, xFE04 and xFE06 return zero. Writes to such addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data from the device page (zero otherwise) |
| mem_en | output | 1 | Enable toward main memory |
| kb_valid | input | 1 | Keyboard byte offered |
| kb_data | input | 8 | Keyboard byte |
| kb_ready | output | 1 | Keyboard byte can be taken |
| dsp_valid | output | 1 | Display byte presented |
| dsp_data | output | 8 | Display byte |
| dsp_accept | input | 1 | Display sink takes the byte |
| kb_irq | output | 1 | Keyboard interrupt request |
| dsp_irq | output | 1 | Display interrupt request |

## Verification
Directed sequences run each channel through a full handshake. They also cover the stall that a second keyboard byte meets, a display write that arrives while the channel is busy, and the xFDFF/xFE00 boundary. Together these separate a device that drops or overwrites characters from one that holds them. Random traffic mixes reads and writes over the four registers, the unused page addresses and memory addresses, with random stream activity on both sides. That traffic brings out same-cycle collisions, such as a data read meeting a new byte or a display write meeting an accept, and it tests the interrupt-enable bits against every ready state.

// File: rtl/kdp_pkg.sv
package kdp_pkg;

    localparam int unsigned ADDR_W = 16;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned CHAR_W = 8;

    localparam logic [ADDR_W-1:0] PAGE_BASE = 16'hFE00;
    localparam logic [ADDR_W-1:0] A_KSTAT   = 16'hFE00;
    localparam logic [ADDR_W-1:0] A_KDATA   = 16'hFE02;
    localparam logic [ADDR_W-1:0] A_DSTAT   = 16'hFE04;
    localparam logic [ADDR_W-1:0] A_DDATA   = 16'hFE06;

    localparam int unsigned RDY_BIT = 15;
    localparam int unsigned IE_BIT  = 14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_KSTAT,
        SEL_KDATA,
        SEL_DSTAT,
        SEL_DDATA
    } reg_sel_e;

    typedef enum logic {
        KB_EMPTY,
        KB_FULL
    } kb_state_e;

    typedef enum logic {
        DS_IDLE,
        DS_BUSY
    } ds_state_e;

endpackage

// File: rtl/kdp_decode.sv
module kdp_decode
    import kdp_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic          bus_req,
    input  logic [AW-1:0] bus_addr,
    output logic          io_hit,
    output reg_sel_e      sel,
    output logic          mem_en
);

    always_comb begin
        io_hit = (bus_addr >= PAGE_BASE);
        mem_en = bus_req && !io_hit;
        sel    = SEL_NONE;
        if (bus_req && io_hit) begin
            unique case (bus_addr)
                A_KSTAT: sel = SEL_KSTAT;
                A_KDATA: sel = SEL_KDATA;
                A_DSTAT: sel = SEL_DSTAT;
                A_DDATA: sel = SEL_DDATA;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/kdp_kbd_chan.sv
module kdp_kbd_chan
    import kdp_pkg::*;
#(
    parameter int unsigned CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_data,
    output logic          in_ready,
    input  logic          consume,
    output logic          full,
    output logic [CW-1:0] held
);

    kb_state_e state_q, state_d;
    logic      take;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            KB_EMPTY: begin
                if (in_valid) begin
                    take    = 1'b1;
                    state_d = KB_FULL;
                end
            end
            KB_FULL: begin
                if (consume) state_d = KB_EMPTY;
            end
            default: state_d = KB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KB_EMPTY;
            held    <= '0;
        end else begin
            state_q <= state_d;
            if (take) held <= in_data;
        end
    end

    always_comb begin
        in_ready = (state_q == KB_EMPTY);
        full     = (state_q == KB_FULL);
    end

endmodule

// File: rtl/kdp_dsp_chan.sv
module kdp_dsp_chan
    import kdp_pkg::*;
#(
    parameter int unsigned CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wr_byte,
    output logic          out_valid,
    output logic [CW-1:0] out_data,
    input  logic          out_accept,
    output logic          idle
);

    ds_state_e state_q, state_d;
    logic      load;

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            DS_IDLE: begin
                if (wr) begin
                    load    = 1'b1;
                    state_d = DS_BUSY;
                end
            end
            DS_BUSY: begin
                if (out_accept) state_d = DS_IDLE;
            end
            default: state_d = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= DS_IDLE;
            out_data <= '0;
        end else begin
            state_q <= state_d;
            if (load) out_data <= wr_byte;
        end
    end

    always_comb begin
        out_valid = (state_q == DS_BUSY);
        idle      = (state_q == DS_IDLE);
    end

endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
    import kdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              mem_en,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_data,
    output logic              kb_ready,
    output logic              dsp_valid,
    output logic [CHAR_W-1:0] dsp_data,
    input  logic              dsp_accept,
    output logic              kb_irq,
    output logic              dsp_irq
);

    localparam int unsigned PAD_W = WORD_W - CHAR_W;
    localparam int unsigned LOW_W = IE_BIT;

    reg_sel_e          sel;
    logic              io_hit;
    logic              kb_full;
    logic [CHAR_W-1:0] kb_byte;
    logic              ds_idle;
    logic              kb_ie_q;
    logic              ds_ie_q;
    logic              rd_kdata;
    logic              wr_ddata;

    kdp_decode #(.AW(ADDR_W)) u_dec (
        .bus_req (bus_req),
        .bus_addr(bus_addr),
        .io_hit  (io_hit),
        .sel     (sel),
        .mem_en  (mem_en)
    );

    always_comb begin
        rd_kdata = (sel == SEL_KDATA) && !bus_we;
        wr_ddata = (sel == SEL_DDATA) && bus_we;
    end

    kdp_kbd_chan #(.CW(CHAR_W)) u_kbd (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(kb_valid),
        .in_data (kb_data),
        .in_ready(kb_ready),
        .consume (rd_kdata),
        .full    (kb_full),
        .held    (kb_byte)
    );

    kdp_dsp_chan #(.CW(CHAR_W)) u_dsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ddata),
        .wr_byte   (bus_wdata[CHAR_W-1:0]),
        .out_valid (dsp_valid),
        .out_data  (dsp_data),
        .out_accept(dsp_accept),
        .idle      (ds_idle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kb_ie_q <= 1'b0;
            ds_ie_q <= 1'b0;
        end else if (bus_we) begin
            if (sel == SEL_KSTAT) kb_ie_q <= bus_wdata[IE_BIT];
            if (sel == SEL_DSTAT) ds_ie_q <= bus_wdata[IE_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_we) begin
            unique case (sel)
                SEL_KSTAT: bus_rdata = {kb_full, kb_ie_q, {LOW_W{1'b0}}};
                SEL_KDATA: bus_rdata = {{PAD_W{1'b0}}, kb_byte};
                SEL_DSTAT: bus_rdata = {ds_idle, ds_ie_q, {LOW_W{1'b0}}};
                SEL_DDATA: bus_rdata = {{PAD_W{1'b0}}, dsp_data};
                default:   bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        kb_irq  = kb_full && kb_ie_q;
        dsp_irq = ds_idle && ds_ie_q;
    end

endmodule

// File: rtl/kdp_checker.sv
module kdp_checker
    import kdp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              mem_en,
    input logic              kb_valid,
    input logic              kb_ready,
    input logic [CHAR_W-1:0] kb_byte,
    input logic              dsp_valid,
    input logic [CHAR_W-1:0] dsp_data,
    input logic              dsp_accept,
    input logic              kb_irq,
    input logic              dsp_irq
);

    logic rd_kdata;
    assign rd_kdata = bus_req && !bus_we && (bus_addr == A_KDATA);

    p_io_no_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr >= PAGE_BASE) |-> !mem_en);

    p_take_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && kb_ready) |=> !kb_ready);

    p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!kb_ready && !rd_kdata) |=> (!kb_ready && $stable(kb_byte)));

    p_accept_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && dsp_accept) |=> !dsp_valid);

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && !dsp_accept) |=> (dsp_valid && $stable(dsp_data)));

    p_kirq_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        kb_irq |-> !kb_ready);

    p_dirq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_irq |-> !dsp_valid);

endmodule

bind kbd_disp_port kdp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .mem_en    (mem_en),
    .kb_valid  (kb_valid),
    .kb_ready  (kb_ready),
    .kb_byte   (kb_byte),
    .dsp_valid (dsp_valid),
    .dsp_data  (dsp_data),
    .dsp_accept(dsp_accept),
    .kb_irq    (kb_irq),
    .dsp_irq   (dsp_irq)
);

// File: tb/sim_kbd_disp_port.sv
module sim_kbd_disp_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mem_en;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_data = '0;
    logic        kb_ready;
    logic        dsp_valid;
    logic [7:0]  dsp_data;
    logic        dsp_accept = 1'b0;
    logic        kb_irq;
    logic        dsp_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench model of the block state
    bit       m_kfull = 0;
    bit [7:0] m_kbyte = 0;
    bit       m_kie = 0;
    bit       m_dbusy = 0;
    bit [7:0] m_dbyte = 0;
    bit       m_die = 0;

    always #10 clk = ~clk;

    kbd_disp_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_en(mem_en), .kb_valid(kb_valid), .kb_data(kb_data),
        .kb_ready(kb_ready), .dsp_valid(dsp_valid), .dsp_data(dsp_data),
        .dsp_accept(dsp_accept), .kb_irq(kb_irq), .dsp_irq(dsp_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rdata(input bit req, input bit we,
                                              input logic [15:0] a);
        if (!req || we) return 16'h0000;
        case (a)
            16'hFE00: return {m_kfull, m_kie, 14'b0};
            16'hFE02: return {8'h00, m_kbyte};
            16'hFE04: return {!m_dbusy, m_die, 14'b0};
            16'hFE06: return {8'h00, m_dbyte};
            default:  return 16'h0000;
        endcase
    endfunction

    function automatic string rd_tag(input logic [15:0] a);
        if (a < 16'hFE00) return "R2";
        case (a)
            16'hFE00: return "R3";
            16'hFE02: return "R4";
            16'hFE04: return "R7";
            16'hFE06: return "R6";
            default:  return "R11";
        endcase
    endfunction

    // One cycle: drive, check combinational view, advance model, clock.
    task automatic step(input bit req, input bit we, input logic [15:0] a,
                        input logic [15:0] wd, input bit kv, input logic [7:0] kd,
                        input bit dacc);
        bit take;
        @(negedge clk);
        bus_req = req; bus_we = we; bus_addr = a; bus_wdata = wd;
        kb_valid = kv; kb_data = kd; dsp_accept = dacc;
        #1;
        chk("R2", "mem_en", {15'b0, mem_en}, {15'b0, req && (a < 16'hFE00)});
        chk(rd_tag(a), "rdata", bus_rdata, exp_rdata(req, we, a));
        chk("R5", "kb_ready", {15'b0, kb_ready}, {15'b0, !m_kfull});
        chk("R7", "dsp_valid", {15'b0, dsp_valid}, {15'b0, m_dbusy});
        if (m_dbusy) chk("R8", "dsp_data", {8'b0, dsp_data}, {8'b0, m_dbyte});
        chk("R10", "kb_irq", {15'b0, kb_irq}, {15'b0, m_kfull && m_kie});
        chk("R10", "dsp_irq", {15'b0, dsp_irq}, {15'b0, !m_dbusy && m_die});
        // model next state
        take = kv && !m_kfull;
        if (take) begin
            m_kfull = 1; m_kbyte = kd;
        end else if (req && !we && a == 16'hFE02) begin
            m_kfull = 0;
        end
        if (req && we && a == 16'hFE00) m_kie = wd[14];
        if (req && we && a == 16'hFE04) m_die = wd[14];
        if (!m_dbusy && req && we && a == 16'hFE06) begin
            m_dbusy = 1; m_dbyte = wd[7:0];
        end else if (m_dbusy && dacc) begin
            m_dbusy = 0;
        end
        @(posedge clk);
    endtask

    task automatic rd(input logic [15:0] a);
        step(1, 0, a, 16'h0, 0, 8'h00, 0);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        step(1, 1, a, d, 0, 8'h00, 0);
    endtask

    task automatic idle1();
        step(0, 0, 16'h0, 16'h0, 0, 8'h00, 0);
    endtask

    function automatic logic [15:0] pick_addr(input int unsigned r);
        case (r % 10)
            0: return 16'hFE00;
            1: return 16'hFE02;
            2: return 16'hFE04;
            3: return 16'hFE06;
            4: return 16'hFE01;
            5: return 16'hFE08;
            6: return 16'hFFFE;
            7: return 16'hFDFF;
            8: return 16'h0000;
            default: return 16'($urandom());
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "kb_ready", {15'b0, kb_ready}, 16'h0001);
        chk("R1", "dsp_valid", {15'b0, dsp_valid}, 16'h0000);
        chk("R1", "irqs", {14'b0, kb_irq, dsp_irq}, 16'h0000);
        rd(16'hFE00);
        rd(16'hFE04);

        // R2 boundary
        rd(16'hFDFF);
        wr(16'hFDFF, 16'hFFFF);
        rd(16'hFE00);

        // R3 / R5 / R4 keyboard handshake
        step(0, 0, 16'h0, 16'h0, 1, 8'h41, 0);
        rd(16'hFE00);
        step(0, 0, 16'h0, 16'h0, 1, 8'h99, 0);   // R5 stalled byte
        step(1, 0, 16'hFE02, 16'h0, 1, 8'h77, 0); // R4 read returns 0x41
        rd(16'hFE00);
        chk("R4", "kb_ready_after_read", {15'b0, kb_ready}, 16'h0001);
        wr(16'hFE02, 16'h00AA);                    // R9 ignored write

        // R6 / R8 / R7 display handshake
        wr(16'hFE06, 16'hAB5A);
        rd(16'hFE06);
        wr(16'hFE06, 16'h0011);                    // R8 ignored
        rd(16'hFE04);
        step(0, 0, 16'h0, 16'h0, 0, 8'h00, 1);     // R7 accept
        rd(16'hFE04);

        // R9 / R10 enables
        wr(16'hFE00, 16'h4000);
        wr(16'hFE04, 16'h3FFF);                    // bit14 clear
        wr(16'hFE04, 16'hC000);                    // R9 bit15 ignored
        rd(16'hFE00);
        rd(16'hFE04);
        step(0, 0, 16'h0, 16'h0, 1, 8'h5C, 0);
        idle1();
        rd(16'hFE02);

        // R11 unused page addresses
        wr(16'hFE01, 16'hFFFF);
        wr(16'hFE08, 16'hFFFF);
        rd(16'hFE01);
        rd(16'hFE08);
        rd(16'hFFFF);
        rd(16'hFE00);
        rd(16'hFE04);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom();
            step(r[0] | r[1], r[2], pick_addr($urandom()), 16'($urandom()),
                 r[3], 8'($urandom()), r[4] & r[5]);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule